// File: doc/BRIEF.md
# Windowed Command and Interrupt-Status Unit

This unit is the command and status front end of a network adapter's host register port. The host writes one 16-bit command word at a time. The word carries a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. Some opcodes change state held inside the unit: the register window number, the cause bits, the interrupt-enable mask and the indication mask. Every accepted command is also passed on, one cycle later, as a single-cycle strobe with its opcode and argument, so that the transmit, receive and diagnostic logic can act on it.

The host reads back one status word. It holds the selected window in bits 15:13, a command-in-progress flag in bit 12 and the indicated cause bits in bits 8:0. Event pulses from the datapath set the cause bits. The host clears them by writing a mask with the acknowledge opcode; reading the status word clears nothing. One interrupt output combines the latch bit with every cause that is both indicated and enabled.

Top module: `hcmd_unit`

## Requirements
- R1: After reset, the status word, the interrupt output, the command strobe and the unit reset select all read zero, and the window is 0.
- R2: Every cycle with `host_wr` high produces a strobe on `cmd_stb` in the next cycle only. During that strobe, `cmd_op` carries bits 15:11 of the written word and `cmd_arg` carries bits 10:0.
- R3: Opcode 1 loads argument bits 2:0 into the window, which status bits 15:13 always show. No other opcode changes the window.
- R4: Opcodes 0, 5 and 11 (global, receive and transmit reset) put argument bits 7:0 on `unit_rst_sel` during their strobe cycle. At every other time `unit_rst_sel` is zero, including during the strobe of any other opcode.
- R5: Opcodes 0, 5, 8 and 11 set status bit 12 for exactly BUSY_CYC cycles, starting in the cycle after the write. The bit then clears without any further command.
- R6: A pulse on `ev_cause` bit 1, 2, 3, 4, 5, 7 or 8 sets the cause bit at the same position. Bits 0 and 6 of `ev_cause` have no effect on any cause.
- R7: Opcode 12 sets cause bit 6, the requested-interrupt cause.
- R8: Opcode 13 clears every cause bit whose position is set in argument bits 8:0. When an event sets a bit in the same cycle as that bit is acknowledged, the bit ends up set.
- R9: Opcode 15 loads argument bits 8:0 as the indication mask. Status bits 8:0 equal the held causes ANDed with this mask, and bits 11:9 read zero. Cause bits are held whatever the mask is.
- R10: Opcode 14 loads argument bits 8:0 as the interrupt-enable mask. `irq` is high when cause bit 0 is set, or when any of cause bits 8:1 is set with both its indication and enable bits set.
- R11: Cause bit 0 (the latch) sets whenever an event or a request sets a cause among bits 8:1 whose enable bit is 1. Only an acknowledge with argument bit 0 clears it, and a new setting in the same cycle wins over that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write to the command offset |
| host_wdata | input | 16 | Command word: opcode 15:11, argument 10:0 |
| ev_cause | input | 9 | Single-cycle cause events from the datapath, one per cause position |
| host_status | output | 16 | Status word: window, busy flag, indicated causes |
| irq | output | 1 | Interrupt request |
| cmd_stb | output | 1 | One-cycle strobe for an accepted command |
| cmd_op | output | 5 | Opcode of the strobed command |
| cmd_arg | output | 11 | Argument of the strobed command |
| unit_rst_sel | output | 8 | Sub-unit reset select, valid during a reset strobe |

## Verification
The assertions check the following on every cycle: a write is followed by exactly one strobe, a window command lands in the window register, a busy command raises the busy flag and the busy count stays bounded, an event always wins over an acknowledge, and an acknowledge without a competing event clears its bits. Only the bench's scenarios can show the rest. That covers the exact busy length measured at the status port, the masking of causes by the indication mask, and the interrupt output across combinations of enable, indication and latch. It also covers the checks that event bits 0 and 6 and non-reset opcodes leave causes and reset selects alone.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  localparam int OP_W    = 5;
  localparam int ARG_W   = 11;
  localparam int WORD_W  = OP_W + ARG_W;
  localparam int WIN_W   = 3;
  localparam int NCAUSE  = 9;
  localparam int SEL_W   = 8;

  localparam logic [OP_W-1:0] OP_GLOBAL_RST = 5'd0;
  localparam logic [OP_W-1:0] OP_WINDOW     = 5'd1;
  localparam logic [OP_W-1:0] OP_RX_RST     = 5'd5;
  localparam logic [OP_W-1:0] OP_DISCARD    = 5'd8;
  localparam logic [OP_W-1:0] OP_TX_RST     = 5'd11;
  localparam logic [OP_W-1:0] OP_REQ_IRQ    = 5'd12;
  localparam logic [OP_W-1:0] OP_ACK        = 5'd13;
  localparam logic [OP_W-1:0] OP_SET_IEN    = 5'd14;
  localparam logic [OP_W-1:0] OP_SET_IND    = 5'd15;

  localparam int CAUSE_LATCH = 0;
  localparam int CAUSE_REQ   = 6;
  // cause positions that datapath events may set
  localparam logic [NCAUSE-1:0] EV_ALLOW = 9'h1BE;
endpackage

// File: rtl/hcmd_decode.sv
module hcmd_decode
  import hcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              dec_win,
  output logic              dec_ack,
  output logic              dec_req,
  output logic              dec_ien,
  output logic              dec_ind,
  output logic              dec_busy,
  output logic [ARG_W-1:0]  dec_arg,
  output logic              stb_q,
  output logic [OP_W-1:0]   op_q,
  output logic [ARG_W-1:0]  arg_q,
  output logic [SEL_W-1:0]  rsel_q
);
  logic [OP_W-1:0]  op;
  logic             is_rst;
  logic             stb_d;
  logic [OP_W-1:0]  op_d;
  logic [ARG_W-1:0] arg_d;
  logic [SEL_W-1:0] rsel_d;

  always_comb begin
    op       = wr_data[WORD_W-1:ARG_W];
    dec_arg  = wr_data[ARG_W-1:0];
    is_rst   = (op == OP_GLOBAL_RST) || (op == OP_RX_RST) || (op == OP_TX_RST);
    dec_win  = wr_en && (op == OP_WINDOW);
    dec_ack  = wr_en && (op == OP_ACK);
    dec_req  = wr_en && (op == OP_REQ_IRQ);
    dec_ien  = wr_en && (op == OP_SET_IEN);
    dec_ind  = wr_en && (op == OP_SET_IND);
    dec_busy = wr_en && (is_rst || (op == OP_DISCARD));
    stb_d    = wr_en;
    op_d     = wr_en ? op : op_q;
    arg_d    = wr_en ? dec_arg : arg_q;
    rsel_d   = (wr_en && is_rst) ? dec_arg[SEL_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      op_q   <= '0;
      arg_q  <= '0;
      rsel_q <= '0;
    end else begin
      stb_q  <= stb_d;
      op_q   <= op_d;
      arg_q  <= arg_d;
      rsel_q <= rsel_d;
    end
  end

  p_stb_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stb_q);
  p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !stb_q);
  p_rsel_only_on_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> (rsel_q == '0));
endmodule

// File: rtl/hcmd_busy.sv
module hcmd_busy #(
  parameter int BUSY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? CNT_LOAD : (cnt_q - 1'b1);
    busy   = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);
endmodule

// File: rtl/hcmd_causes.sv
module hcmd_causes
  import hcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] ev,
  input  logic              req,
  input  logic              ack,
  input  logic              ien_ld,
  input  logic              ind_ld,
  input  logic [NCAUSE-1:0] mask_in,
  output logic [NCAUSE-1:0] cause_q,
  output logic [NCAUSE-1:0] ien_q,
  output logic [NCAUSE-1:0] ind_q
);
  logic [NCAUSE-1:0] raw_set;
  logic [NCAUSE-1:0] set_vec;
  logic [NCAUSE-1:0] clr_vec;
  logic [NCAUSE-1:0] cause_d;
  logic              latch_set;

  always_comb begin
    raw_set = ev & EV_ALLOW;
    raw_set[CAUSE_REQ] = req;
    latch_set = |(raw_set & ien_q & ~(NCAUSE'(1) << CAUSE_LATCH));
    set_vec = raw_set;
    set_vec[CAUSE_LATCH] = latch_set;
    clr_vec = ack ? mask_in : '0;
  end

  for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
    always_comb cause_d[i] = set_vec[i] | (cause_q[i] & ~clr_vec[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q[i] <= 1'b0;
      else        cause_q[i] <= cause_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ind_q <= '0;
    end else begin
      if (ien_ld) ien_q <= mask_in;
      if (ind_ld) ind_q <= mask_in;
    end
  end

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));
  p_event_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && |(mask_in & set_vec)) |=> ((cause_q & $past(mask_in & set_vec)) != '0));
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((cause_q & $past(mask_in & ~set_vec)) == '0));
endmodule

// File: rtl/hcmd_unit.sv
module hcmd_unit
  import hcmd_pkg::*;
#(
  parameter int BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [15:0]       host_wdata,
  input  logic [8:0]        ev_cause,
  output logic [15:0]       host_status,
  output logic              irq,
  output logic              cmd_stb,
  output logic [4:0]        cmd_op,
  output logic [10:0]       cmd_arg,
  output logic [7:0]        unit_rst_sel
);
  logic             dec_win, dec_ack, dec_req, dec_ien, dec_ind, dec_busy;
  logic [ARG_W-1:0] dec_arg;
  logic             busy;
  logic [NCAUSE-1:0] cause_q, ien_q, ind_q;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;

  hcmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_data(host_wdata),
    .dec_win(dec_win), .dec_ack(dec_ack), .dec_req(dec_req),
    .dec_ien(dec_ien), .dec_ind(dec_ind), .dec_busy(dec_busy),
    .dec_arg(dec_arg), .stb_q(cmd_stb), .op_q(cmd_op), .arg_q(cmd_arg),
    .rsel_q(unit_rst_sel)
  );

  hcmd_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(dec_busy), .busy(busy)
  );

  hcmd_causes u_cause (
    .clk(clk), .rst_n(rst_n), .ev(ev_cause), .req(dec_req), .ack(dec_ack),
    .ien_ld(dec_ien), .ind_ld(dec_ind), .mask_in(dec_arg[NCAUSE-1:0]),
    .cause_q(cause_q), .ien_q(ien_q), .ind_q(ind_q)
  );

  always_comb win_d = dec_arg[WIN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_q <= '0;
    else if (dec_win) win_q <= win_d;
  end

  always_comb begin
    host_status = {win_q, busy, 3'b000, cause_q & ind_q};
    irq = cause_q[CAUSE_LATCH] |
          (|(cause_q & ind_q & ien_q & ~(NCAUSE'(1) << CAUSE_LATCH)));
  end

  p_window_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_wdata[15:11] == OP_WINDOW) |=> (host_status[15:13] == $past(host_wdata[2:0])));
  p_window_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_wdata[15:11] == OP_WINDOW) |=> $stable(host_status[15:13]));
  p_zero_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[11:9] == 3'b000);
endmodule

// File: tb/test_hcmd_unit.sv
module test_hcmd_unit;
  localparam int BC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [8:0]  ev_cause = '0;
  logic [15:0] host_status;
  logic        irq, cmd_stb;
  logic [4:0]  cmd_op;
  logic [10:0] cmd_arg;
  logic [7:0]  unit_rst_sel;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side expectation state
  logic [8:0]  m_cause = '0, m_ien = '0, m_ind = '0;
  logic [2:0]  m_win = '0;
  int          m_cnt = 0;

  always #4 clk = ~clk;

  hcmd_unit #(.BUSY_CYC(BC)) i_hcmd_unit (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .ev_cause(ev_cause), .host_status(host_status), .irq(irq),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .unit_rst_sel(unit_rst_sel)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update expectations, check at next negedge
  task automatic step(input string tag, input logic wr, input logic [4:0] op, input logic [10:0] arg, input logic [8:0] ev);
    logic [8:0] raw, setv, ackm;
    logic       bop, rop;
    @(negedge clk);
    host_wr = wr; host_wdata = {op, arg}; ev_cause = ev;
    raw  = ev & 9'h1BE;
    if (wr && op == 5'd12) raw[6] = 1'b1;
    setv = raw;
    setv[0] = |(raw & m_ien & 9'h1FE);
    ackm = (wr && op == 5'd13) ? arg[8:0] : 9'h000;
    m_cause = (m_cause & ~ackm) | setv;
    if (wr && op == 5'd1)  m_win = arg[2:0];
    if (wr && op == 5'd14) m_ien = arg[8:0];
    if (wr && op == 5'd15) m_ind = arg[8:0];
    rop = wr && (op == 5'd0 || op == 5'd5 || op == 5'd11);
    bop = rop || (wr && op == 5'd8);
    if (bop) m_cnt = BC; else if (m_cnt > 0) m_cnt--;
    @(negedge clk);
    host_wr = 1'b0; ev_cause = '0;
    chk(tag, "status", 32'(host_status), 32'({m_win, (m_cnt > 0), 3'b000, m_cause & m_ind}));
    chk(tag, "irq", 32'(irq), 32'(m_cause[0] | (|(m_cause & m_ind & m_ien & 9'h1FE))));
    chk(tag, "stb", 32'(cmd_stb), 32'(wr));
    if (wr) begin
      chk(tag, "op", 32'(cmd_op), 32'(op));
      chk(tag, "arg", 32'(cmd_arg), 32'(arg));
    end
    chk(tag, "rsel", 32'(unit_rst_sel), rop ? 32'(arg[7:0]) : 32'd0);
    // leave the sampled cycle idle so every step spans two edges
    if (m_cnt > 0) m_cnt--;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 5'd0, 11'd0, 9'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "status", 32'(host_status), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);
    chk("R1", "stb", 32'(cmd_stb), 32'd0);
    chk("R1", "rsel", 32'(unit_rst_sel), 32'd0);

    // R3 / R2 every window value, with noise in the upper argument bits
    for (int w = 0; w < 8; w++) step("R3", 1'b1, 5'd1, {8'(8'h5A ^ w), 3'(w)}, 9'd0);
    step("R3", 1'b1, 5'd15, 11'h000, 9'd0);
    step("R2", 1'b1, 5'd31, 11'h7FF, 9'd0);

    // R4 / R5 each busy opcode; steps are two cycles so busy of 5 spans three steps
    begin
      logic [4:0] bops [4] = '{5'd0, 5'd5, 5'd11, 5'd8};
      for (int k = 0; k < 4; k++) begin
        step("R4", 1'b1, bops[k], 11'(11'h600 | (11'h3C << k)), 9'd0);
        for (int j = 0; j < 3; j++) idle("R5");
      end
    end
    // R4 non-reset opcode keeps rsel at zero
    step("R4", 1'b1, 5'd12, 11'h0FF, 9'd0);
    step("R8", 1'b1, 5'd13, 11'h1FF, 9'd0);

    // R6 every event position with all causes indicated, no enables
    step("R9", 1'b1, 5'd15, 11'h1FF, 9'd0);
    for (int b = 0; b < 9; b++) begin
      step("R6", 1'b0, 5'd0, 11'd0, 9'(1 << b));
      step("R8", 1'b1, 5'd13, 11'h1FF, 9'd0);
    end

    // R7 request cause
    step("R7", 1'b1, 5'd12, 11'd0, 9'd0);
    step("R8", 1'b1, 5'd13, 11'h040, 9'd0);

    // R8 event and acknowledge collide on the same bit
    step("R8", 1'b0, 5'd0, 11'd0, 9'h014);
    step("R8", 1'b1, 5'd13, 11'h014, 9'h010);
    step("R8", 1'b1, 5'd13, 11'h010, 9'd0);
    step("R8", 1'b1, 5'd13, 11'h1FF, 9'd0);

    // R9 indication masks over held causes
    step("R6", 1'b0, 5'd0, 11'd0, 9'h1BE);
    step("R7", 1'b1, 5'd12, 11'd0, 9'd0);
    for (int m = 0; m < 512; m += 37) step("R9", 1'b1, 5'd15, 11'(m), 9'd0);
    step("R8", 1'b1, 5'd13, 11'h1FF, 9'd0);

    // R10 / R11 enable sweep: each cause alone, indicated and not
    for (int k = 1; k < 9; k++) begin
      step("R10", 1'b1, 5'd14, 11'(1 << k), 9'd0);
      step("R9", 1'b1, 5'd15, (k % 2 == 1) ? 11'h1FF : 11'(9'h1FF & ~(9'(1) << k)), 9'd0);
      if (k == 6) step("R11", 1'b1, 5'd12, 11'd0, 9'd0);
      else        step("R11", 1'b0, 5'd0, 11'd0, 9'(1 << k));
      step("R10", 1'b1, 5'd13, 11'(1 << k), 9'd0);
      step("R11", 1'b1, 5'd13, 11'h001, 9'd0);
      // cause set with enable off must not raise the latch
      step("R10", 1'b1, 5'd14, 11'd0, 9'd0);
      if (k == 6) step("R11", 1'b1, 5'd12, 11'd0, 9'd0);
      else        step("R11", 1'b0, 5'd0, 11'd0, 9'(1 << k));
      step("R10", 1'b1, 5'd14, 11'h1FE, 9'd0);
      step("R8", 1'b1, 5'd13, 11'h1FF, 9'd0);
    end
    // R11 latch setting beats acknowledge of the latch
    step("R11", 1'b1, 5'd14, 11'h004, 9'd0);
    step("R11", 1'b1, 5'd13, 11'h001, 9'h004);
    step("R11", 1'b1, 5'd13, 11'h1FF, 9'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule